// File: doc/BRIEF.md
# Push-Button Power State Controller

This block decides whether the device is off or on. An active-low push-button and a supply-good flag from an undervoltage comparator qualify the turn-on. A 1 kHz tick times the button: the button has to stay low for more than a set number of ticks in a row. Once that test passes, the controller steps through the start-up. It first requests the system supply ramp, then the load of the register defaults, then enables the rails one at a time. Each step waits for a done handshake from the analog side.

While the device is on, the host bus and the auxiliary converter request are let through. A host processor holds the device on by raising a hold input before the button is released. Releasing the button while the hold input is low turns the device off, and so does losing the supply at any time. A 2-bit lockout level code can be written by the host while the device is on. The code goes to the comparator and returns to its default whenever the device turns off.

Top module: `pb_power_ctrl`

## Requirements
- R1: `ramp_en` rises only after `btn_n` has been low through more than `DB_TICKS` (default 50) consecutive `tick_1k` pulses. A high level on `btn_n` before that point restarts the count from zero.
- R2: No turn-on happens while `supply_ok` is low, however long the button is held. Once the button has been qualified, `supply_ok` going high starts the sequence on the next clock.
- R3: Start-up order. `ramp_en` comes first and stays high while the device is powered. `load_req` is high only after `ramp_done`, until `load_done`. Then `rail_en` bits turn on one per `rail_done`, starting at bit 0 and going up, and enabled rails stay on. No step advances without its handshake.
- R4: `bus_en` is high only after the last rail has been acknowledged (the on state). `aux_en` equals `aux_req` while `bus_en` is high and is 0 otherwise.
- R5: In any powered state, `btn_n` high with `hold_on` low turns the device off at the next clock edge. With `hold_on` high, releasing the button keeps it on.
- R6: `supply_ok` low in any powered state turns the device off at the next edge. All `rail_en` bits, `ramp_en`, `load_req` and `bus_en` drop together.
- R7: `uvlo_sel` is the lockout code: 00 = 3.0 V (default), 01 = 3.1 V, 10 = 3.2 V, 11 = 3.3 V. A pulse on `lvl_wr` loads `lvl_wdata` only in the on state. Writes at other times are ignored.
- R8: Entering the off state returns `uvlo_sel` to 00 and clears the debounce count. A new qualified press is then needed to turn on again, even if the button was never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz for debounce timing |
| btn_n | input | 1 | Push-button, low when pressed |
| supply_ok | input | 1 | System supply above the lockout level |
| hold_on | input | 1 | Host keep-on request |
| ramp_done | input | 1 | System supply ramp finished |
| load_done | input | 1 | Register defaults loaded |
| rail_done | input | 1 | Current rail reached regulation |
| aux_req | input | 1 | Auxiliary converter enable request |
| lvl_wr | input | 1 | Lockout code write strobe from the host bus |
| lvl_wdata | input | 2 | Lockout code to write |
| ramp_en | output | 1 | System supply ramp enable |
| load_req | output | 1 | Load register defaults request |
| rail_en | output | NUM_RAILS | Rail enables, bit 0 first |
| bus_en | output | 1 | Host bus interface enable |
| aux_en | output | 1 | Gated auxiliary converter enable |
| uvlo_sel | output | 2 | Lockout level code to the comparator |

## Verification
A wrong state shows at the ports within one clock. `ramp_en`, `load_req`, `rail_en` and `bus_en` are decoded straight from the state register, so a skipped or repeated step shows up as a wrong enable pattern right after the handshake edge. A debounce count that is off by one moves the `ramp_en` rise by exactly one tick, so the bench checks the tick just before the limit and the tick at the limit. A lockout code that is not cleared shows on `uvlo_sel` as soon as the device is off.

// File: rtl/pb_power_ctrl.sv
module pb_power_ctrl #(
  parameter int DB_TICKS  = 50,
  parameter int NUM_RAILS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1k,
  input  logic                 btn_n,
  input  logic                 supply_ok,
  input  logic                 hold_on,
  input  logic                 ramp_done,
  input  logic                 load_done,
  input  logic                 rail_done,
  input  logic                 aux_req,
  input  logic                 lvl_wr,
  input  logic [1:0]           lvl_wdata,
  output logic                 ramp_en,
  output logic                 load_req,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 bus_en,
  output logic                 aux_en,
  output logic [1:0]           uvlo_sel
);
  localparam int CW = $clog2(DB_TICKS + 2);
  localparam int IW = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NUM_RAILS - 1);

  typedef enum logic [2:0] {S_OFF, S_RAMP, S_LOAD, S_RAIL, S_ON} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [1:0]    code;

  wire pressed = cnt > CW'(DB_TICKS);
  wire drop    = (btn_n && !hold_on) || !supply_ok;

  always_comb begin
    st_nx = st;
    if (st == S_OFF) begin
      if (pressed && !btn_n && supply_ok) st_nx = S_RAMP;
    end else if (drop) begin
      st_nx = S_OFF;
    end else begin
      case (st)
        S_RAMP:  if (ramp_done) st_nx = S_LOAD;
        S_LOAD:  if (load_done) st_nx = S_RAIL;
        S_RAIL:  if (rail_done && idx == LAST) st_nx = S_ON;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      cnt  <= '0;
      idx  <= '0;
      code <= 2'b00;
    end else begin
      st <= st_nx;
      if (st != S_OFF || btn_n) cnt <= '0;
      else if (tick_1k && !pressed) cnt <= cnt + 1'b1;
      if (st != S_RAIL) idx <= '0;
      else if (rail_done && idx != LAST) idx <= idx + 1'b1;
      if (st_nx == S_OFF) code <= 2'b00;
      else if (st == S_ON && lvl_wr) code <= lvl_wdata;
    end
  end

  assign ramp_en  = st != S_OFF;
  assign load_req = st == S_LOAD;
  assign bus_en   = st == S_ON;
  assign aux_en   = aux_req && bus_en;
  assign uvlo_sel = code;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    assign rail_en[i] = (st == S_ON) || (st == S_RAIL && idx >= IW'(i));
  end

  a_r1_press_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> $past(!btn_n) && $past(pressed));
  a_r2_supply_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> $past(supply_ok));
  a_r3_one_rail_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en) <= $countones($past(rail_en)) + 1);
  a_r4_aux_gated: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |-> bus_en && aux_req);
  a_r5_release_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && btn_n && !hold_on) |=> !ramp_en && !bus_en);
  a_r6_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !supply_ok) |=> !ramp_en && rail_en == '0 && !load_req);
  a_r8_code_default: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |-> uvlo_sel == 2'b00);
endmodule

// File: tb/pb_power_ctrl_tb.sv
module pb_power_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic tick_1k = 0, btn_n = 1, supply_ok = 1, hold_on = 0;
  logic ramp_done = 0, load_done = 0, rail_done = 0, aux_req = 0, lvl_wr = 0;
  logic [1:0] lvl_wdata = 0;
  logic ramp_en, load_req, bus_en, aux_en;
  logic [2:0] rail_en;
  logic [1:0] uvlo_sel;
  int tests = 0, fails = 0;
  bit done = 0;

  string      tq[$];
  logic [8:0] eq[$];

  always #2.5 clk = ~clk;

  pb_power_ctrl #(.DB_TICKS(50), .NUM_RAILS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .btn_n(btn_n),
    .supply_ok(supply_ok), .hold_on(hold_on), .ramp_done(ramp_done),
    .load_done(load_done), .rail_done(rail_done), .aux_req(aux_req),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .ramp_en(ramp_en),
    .load_req(load_req), .rail_en(rail_en), .bus_en(bus_en),
    .aux_en(aux_en), .uvlo_sel(uvlo_sel));

  wire [8:0] obs = {ramp_en, load_req, rail_en, bus_en, aux_en, uvlo_sel};

  function automatic logic [8:0] ex(bit r, bit l, bit [2:0] rl, bit b, bit a, bit [1:0] s);
    return {r, l, rl, b, a, s};
  endfunction

  initial forever begin
    @(negedge clk);
    if (eq.size() > 0) begin
      automatic logic [8:0] e = eq.pop_front();
      automatic string t = tq.pop_front();
      tests++;
      if (obs !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, obs, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [8:0] e);
    tq.push_back(tag);
    eq.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      tick_1k = 1; step(); tick_1k = 0; step();
    end
  endtask

  task automatic pulse(int which);
    case (which)
      0: ramp_done = 1;
      1: load_done = 1;
      default: rail_done = 1;
    endcase
    step();
    ramp_done = 0; load_done = 0; rail_done = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    chk("reset state", ex(0,0,3'b000,0,0,2'b00));
    rst_n = 1; step();
    // R1: debounce restart and exact limit
    btn_n = 0; tk(30); btn_n = 1; step(); btn_n = 0; tk(50);
    chk("R1 not yet after 50 ticks", ex(0,0,3'b000,0,0,0));
    tk(1);
    chk("R1 on after 51 ticks", ex(1,0,3'b000,0,0,0));
    // R3: handshake order
    step(); step();
    chk("R3 waits for ramp_done", ex(1,0,3'b000,0,0,0));
    pulse(0);
    chk("R3 load after ramp", ex(1,1,3'b000,0,0,0));
    pulse(1);
    chk("R3 rail0 after load", ex(1,0,3'b001,0,0,0));
    aux_req = 1;
    pulse(2);
    chk("R4 aux blocked during rails / R3 rail1", ex(1,0,3'b011,0,0,0));
    pulse(2);
    chk("R3 rail2", ex(1,0,3'b111,0,0,0));
    pulse(2);
    chk("R4 on with aux", ex(1,0,3'b111,1,1,0));
    aux_req = 0; step();
    chk("R4 aux follows request", ex(1,0,3'b111,1,0,0));
    // R7: code write in on state
    lvl_wr = 1; lvl_wdata = 2'b10; step(); lvl_wr = 0;
    chk("R7 code write 3.2V", ex(1,0,3'b111,1,0,2'b10));
    // R5: hold keeps on after release
    hold_on = 1; btn_n = 1; step(); step();
    chk("R5 held on after release", ex(1,0,3'b111,1,0,2'b10));
    hold_on = 0; step();
    chk("R5/R8 off on hold drop, code cleared", ex(0,0,3'b000,0,0,0));
    lvl_wr = 1; lvl_wdata = 2'b11; step(); lvl_wr = 0;
    chk("R7 write ignored in off", ex(0,0,3'b000,0,0,0));
    // R2: supply gate
    supply_ok = 0; btn_n = 0; tk(60);
    chk("R2 no turn-on without supply", ex(0,0,3'b000,0,0,0));
    supply_ok = 1; step();
    chk("R2 on once supply good", ex(1,0,3'b000,0,0,0));
    // R6: supply loss mid-sequence
    pulse(0); pulse(1); pulse(2);
    chk("R6 precondition two rails", ex(1,0,3'b011,0,0,0));
    supply_ok = 0; step();
    chk("R6 all drop on supply loss", ex(0,0,3'b000,0,0,0));
    supply_ok = 1; step(); step();
    chk("R8 new press needed", ex(0,0,3'b000,0,0,0));
    // R5: release during start-up without hold
    tk(51);
    chk("R8 re-qualified press", ex(1,0,3'b000,0,0,0));
    btn_n = 1; step();
    chk("R5 release without hold in ramp", ex(0,0,3'b000,0,0,0));
    // R6 from on state
    btn_n = 0; tk(51); hold_on = 1;
    pulse(0); pulse(1); pulse(2); pulse(2); pulse(2);
    chk("R8 code default after re-entry", ex(1,0,3'b111,1,0,0));
    btn_n = 1; supply_ok = 0; step();
    chk("R6 off from on state", ex(0,0,3'b000,0,0,0));
    done = 1;
    finish_run();
  end
endmodule